// File: doc/BRIEF.md
# Embedded video sync decoder

This block watches a pixel-rate video stream whose line and frame timing is carried inside the data itself, as reserved four-word codes, rather than on separate sync wires. It finds each timing code, checks the protection bits of its status word, and recovers the frame position from it. It reports that position as field, vertical-blanking and horizontal-blanking flags. It also emits a one-cycle pulse for every start-of-active-video and end-of-active-video code, and it strobes out the samples that belong to the active picture.

Each lane is `LANE_W` bits wide, and only its top eight bits are used. A 10-bit sample is therefore reduced to 8 bits, and two 10-bit lanes give 16 bits. With `dual_lane` low, one sample per clock arrives on the luma lane. With `dual_lane` high, a luma sample and a chroma sample arrive together on every clock. Timing codes are recognised on the luma lane only.

Top module: `vsync_code_decoder`

## Requirements
- R1: After reset the outputs read field 0, vertical blanking 1, horizontal blanking 1. The strobe, the code pulses and the error flag are all 0.
- R2: A timing code is four consecutive luma words: 0xFF, 0x00, 0x00 and then a status word. Only the top 8 bits of each lane take part, so the low `LANE_W-8` bits never change the result.
- R3: On a valid status word, the field, vertical and horizontal outputs take status bits 6, 5 and 4 one cycle after the status word is sampled. They describe the samples that follow the code.
- R4: A valid status word with bit 4 = 0 gives a one-cycle start pulse, and one with bit 4 = 1 gives a one-cycle end pulse. The two pulses are never high together.
- R5: A status word is valid only when bit 7 = 1, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. An invalid status word gives a one-cycle error pulse and no start or end pulse, and it leaves the flags and the active-video state unchanged.
- R6: A 0xFF word starts a new candidate code wherever it occurs, including inside a partial code. A broken preamble never gives a pulse.
- R7: The strobe is high for samples that follow a valid start code with V = 0, up to the next valid end code. A start code with V = 1 does not open active video.
- R8: The strobe stays low for any sample that belongs to a code: a 0xFF word, a 0x00 word that continues a partial preamble, and the status word.
- R9: The chroma lane never affects code detection. In dual-lane mode the chroma output carries the top 8 chroma bits, and in single-lane mode it reads 0.
- R10: The luma and chroma outputs carry the top 8 bits of the sample that was taken in the same cycle that produces the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_lane | input | 1 | 1: luma and chroma lanes, 0: single sample lane |
| luma_in | input | LANE_W | Luma / single sample lane |
| chroma_in | input | LANE_W | Chroma lane (dual-lane mode) |
| field_o | output | 1 | Field flag of the last valid code |
| vblank_o | output | 1 | Vertical blanking flag |
| hblank_o | output | 1 | Horizontal blanking flag |
| sav_o | output | 1 | One-cycle start-of-active-video pulse |
| eav_o | output | 1 | One-cycle end-of-active-video pulse |
| prot_err_o | output | 1 | One-cycle status protection error |
| act_valid_o | output | 1 | Active picture sample strobe |
| act_luma_o | output | 8 | Active luma sample, top 8 bits |
| act_chroma_o | output | 8 | Active chroma sample, or 0 in single-lane mode |

## Verification
Every one of the eight flag combinations is sent as a clean code, with random low bits on the lanes. This separates correct flag decoding from accidental dependence on the dropped bits. Corrupted status words are sent in two forms, one with a single protection bit flipped and one with bit 7 cleared, and the held flags show that errors are rejected rather than merged in. Interrupted and restarted preambles show the restart-on-0xFF rule. A start code inside vertical blanking, and a complete code placed on the chroma lane alone, show that neither one opens active video. Active lines in both lane modes check the strobe edges around the codes and the data on both lanes.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int CW = 8;
  localparam logic [CW-1:0] SYNC_HI = 8'hFF;
  localparam logic [CW-1:0] SYNC_LO = 8'h00;

  typedef enum logic [1:0] {M_IDLE, M_FF, M_FF0, M_FF00} match_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } flags_t;

  function automatic logic [3:0] guard_bits(input flags_t x);
    return {x.v ^ x.h, x.f ^ x.h, x.f ^ x.v, x.f ^ x.v ^ x.h};
  endfunction

  function automatic flags_t status_flags(input logic [CW-1:0] w);
    flags_t x;
    x.f = w[6];
    x.v = w[5];
    x.h = w[4];
    return x;
  endfunction

  function automatic logic status_word_ok(input logic [CW-1:0] w);
    return w[7] && (w[3:0] == guard_bits(status_flags(w)));
  endfunction
endpackage

// File: rtl/vsd_preamble.sv
module vsd_preamble
  import vsd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] word,
  output logic          status_slot,
  output logic          code_slot
);
  match_e st_q, st_d;
  logic   is_hi, is_lo, mid_pre;

  assign is_hi   = (word == SYNC_HI);
  assign is_lo   = (word == SYNC_LO);
  assign mid_pre = (st_q == M_FF) || (st_q == M_FF0);

  always_comb begin
    st_d = M_IDLE;
    if (is_hi)                       st_d = M_FF;
    else if (st_q == M_FF  && is_lo) st_d = M_FF0;
    else if (st_q == M_FF0 && is_lo) st_d = M_FF00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

  assign status_slot = (st_q == M_FF00);
  assign code_slot   = status_slot || is_hi || (mid_pre && is_lo);
endmodule

// File: rtl/vsd_status.sv
module vsd_status
  import vsd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          status_slot,
  input  logic [CW-1:0] word,
  output flags_t        flags,
  output logic          sav,
  output logic          eav,
  output logic          perr,
  output logic          act_en
);
  flags_t in_f;
  logic   ok, take;

  assign in_f = status_flags(word);
  assign ok   = status_word_ok(word);
  assign take = status_slot && ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '{f: 1'b0, v: 1'b1, h: 1'b1};
      act_en <= 1'b0;
      sav    <= 1'b0;
      eav    <= 1'b0;
      perr   <= 1'b0;
    end else begin
      sav  <= take && !in_f.h;
      eav  <= take && in_f.h;
      perr <= status_slot && !ok;
      if (take) begin
        flags  <= in_f;
        act_en <= !in_f.h && !in_f.v;
      end
    end
  end
endmodule

// File: rtl/vsd_active.sv
module vsd_active
  import vsd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_en,
  input  logic          code_slot,
  input  logic          dual_lane,
  input  logic [CW-1:0] luma8,
  input  logic [CW-1:0] chroma8,
  output logic          valid,
  output logic [CW-1:0] luma_q,
  output logic [CW-1:0] chroma_q
);
  logic pass;
  assign pass = act_en && !code_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      luma_q   <= '0;
      chroma_q <= '0;
    end else begin
      valid <= pass;
      if (pass) begin
        luma_q   <= luma8;
        chroma_q <= dual_lane ? chroma8 : '0;
      end
    end
  end
endmodule

// File: rtl/vsync_code_decoder.sv
module vsync_code_decoder
  import vsd_pkg::*;
#(
  parameter int LANE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_lane,
  input  logic [LANE_W-1:0] luma_in,
  input  logic [LANE_W-1:0] chroma_in,
  output logic              field_o,
  output logic              vblank_o,
  output logic              hblank_o,
  output logic              sav_o,
  output logic              eav_o,
  output logic              prot_err_o,
  output logic              act_valid_o,
  output logic [7:0]        act_luma_o,
  output logic [7:0]        act_chroma_o
);
  localparam int DROP_W = LANE_W - CW;

  logic [CW-1:0] luma8, chroma8;
  logic          status_slot, code_slot, act_en;
  flags_t        flags;

  assign luma8   = luma_in[LANE_W-1 -: CW];
  assign chroma8 = chroma_in[LANE_W-1 -: CW];

  generate
    if (DROP_W > 0) begin : g_drop
      logic unused_low;
      assign unused_low = ^{luma_in[DROP_W-1:0], chroma_in[DROP_W-1:0]};
    end
  endgenerate

  vsd_preamble u_pre (
    .clk(clk), .rst_n(rst_n), .word(luma8),
    .status_slot(status_slot), .code_slot(code_slot)
  );

  vsd_status u_stat (
    .clk(clk), .rst_n(rst_n), .status_slot(status_slot), .word(luma8),
    .flags(flags), .sav(sav_o), .eav(eav_o), .perr(prot_err_o), .act_en(act_en)
  );

  vsd_active u_act (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .code_slot(code_slot),
    .dual_lane(dual_lane), .luma8(luma8), .chroma8(chroma8),
    .valid(act_valid_o), .luma_q(act_luma_o), .chroma_q(act_chroma_o)
  );

  assign field_o  = flags.f;
  assign vblank_o = flags.v;
  assign hblank_o = flags.h;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
  input logic clk,
  input logic rst_n,
  input logic status_slot,
  input logic code_slot,
  input logic act_en,
  input logic field_o,
  input logic vblank_o,
  input logic hblank_o,
  input logic sav_o,
  input logic eav_o,
  input logic prot_err_o,
  input logic act_valid_o
);
  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sav_o && eav_o));
  assert_sav_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sav_o |=> !sav_o);
  assert_sav_opens_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sav_o |-> !hblank_o);
  assert_eav_closes_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eav_o |-> hblank_o);
  assert_err_holds_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_o |-> ($stable({field_o, vblank_o, hblank_o}) && !sav_o && !eav_o));
  assert_events_follow_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_o || eav_o || prot_err_o) |-> $past(status_slot));
  assert_strobe_in_picture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> (!vblank_o && !hblank_o && $past(act_en)));
  assert_no_strobe_on_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_slot |=> !act_valid_o);
endmodule

bind vsync_code_decoder vsd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status_slot(status_slot), .code_slot(code_slot),
  .act_en(act_en), .field_o(field_o), .vblank_o(vblank_o), .hblank_o(hblank_o),
  .sav_o(sav_o), .eav_o(eav_o), .prot_err_o(prot_err_o), .act_valid_o(act_valid_o)
);

// File: tb/vsync_code_decoder_test.sv
module vsync_code_decoder_test;
  localparam int CLK_P = 10;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual = 1'b0;
  logic [LW-1:0] luma = '0, chroma = '0;
  logic field_o, vblank_o, hblank_o, sav_o, eav_o, prot_err_o, act_valid_o;
  logic [7:0] act_luma_o, act_chroma_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vsync_code_decoder #(.LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .dual_lane(dual), .luma_in(luma), .chroma_in(chroma),
    .field_o(field_o), .vblank_o(vblank_o), .hblank_o(hblank_o), .sav_o(sav_o),
    .eav_o(eav_o), .prot_err_o(prot_err_o), .act_valid_o(act_valid_o),
    .act_luma_o(act_luma_o), .act_chroma_o(act_chroma_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_flags(input string tag, input bit f, input bit v, input bit h);
    chk({field_o, vblank_o, hblank_o} == {f, v, h}, tag,
        {field_o, vblank_o, hblank_o}, {f, v, h});
  endtask

  function automatic logic [7:0] mk_status(input bit f, input bit v, input bit h);
    int s;
    s = 128 + 64*f + 32*v + 16*h;
    s += 8*(v ^ h) + 4*(f ^ h) + 2*(f ^ v) + (f ^ v ^ h);
    return 8'(s);
  endfunction

  // one sample per clock; low bits random, outputs observed just after the edge
  task automatic push(input logic [7:0] y, input logic [7:0] c);
    @(negedge clk);
    luma   = {y, 2'($urandom)};
    chroma = {c, 2'($urandom)};
    @(posedge clk);
    #1;
  endtask

  task automatic preamble();
    push(8'hFF, 8'($urandom));
    push(8'h00, 8'($urandom));
    push(8'h00, 8'($urandom));
  endtask

  task automatic send_code(input bit f, input bit v, input bit h);
    preamble();
    push(mk_status(f, v, h), 8'($urandom));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_flags("R1 reset flags", 1'b0, 1'b1, 1'b1);
    chk({sav_o, eav_o, prot_err_o, act_valid_o} == 4'b0, "R1 reset pulses/strobe",
        {sav_o, eav_o, prot_err_o, act_valid_o}, 0);
  endtask

  task automatic t_single_line();
    logic [7:0] px [3] = '{8'hA1, 8'h3C, 8'h10};
    dual = 1'b0;
    send_code(1'b0, 1'b0, 1'b0);
    chk(sav_o && !eav_o, "R4 start pulse", {sav_o, eav_o}, 2'b10);
    expect_flags("R3 flags after start", 1'b0, 1'b0, 1'b0);
    chk(!act_valid_o, "R8 no strobe on status slot", act_valid_o, 0);
    foreach (px[i]) begin
      push(px[i], 8'h77);
      chk(act_valid_o, "R7 strobe in line", act_valid_o, 1);
      chk(act_luma_o == px[i], "R10 luma data", act_luma_o, px[i]);
      chk(act_chroma_o == 8'h00, "R9 chroma zero in single mode", act_chroma_o, 0);
    end
    chk(!sav_o, "R4 start pulse one cycle", sav_o, 0);
    push(8'hFF, 8'h11);
    chk(!act_valid_o, "R8 no strobe on 0xFF", act_valid_o, 0);
    push(8'h00, 8'h11);
    chk(!act_valid_o, "R8 no strobe on preamble 0x00", act_valid_o, 0);
    push(8'h00, 8'h11);
    chk(!act_valid_o, "R8 no strobe on preamble 0x00", act_valid_o, 0);
    push(mk_status(1'b0, 1'b0, 1'b1), 8'h11);
    chk(eav_o && !sav_o, "R4 end pulse", {sav_o, eav_o}, 2'b01);
    expect_flags("R3 flags after end", 1'b0, 1'b0, 1'b1);
    push(8'h55, 8'h22);
    chk(!act_valid_o, "R7 strobe closed after end", act_valid_o, 0);
  endtask

  task automatic t_all_codes();
    for (int k = 0; k < 8; k++) begin
      bit f, v, h;
      {f, v, h} = 3'(k);
      send_code(f, v, h);
      expect_flags("R3 decoded flags", f, v, h);
      chk(sav_o == !h && eav_o == h, "R4 code type", {sav_o, eav_o}, {!h, h});
      chk(!prot_err_o, "R2 valid code no error", prot_err_o, 0);
    end
  endtask

  task automatic t_prot_err();
    send_code(1'b1, 1'b0, 1'b1);
    preamble();
    push(mk_status(1'b0, 1'b1, 1'b0) ^ 8'h02, 8'h00);
    chk(prot_err_o && !sav_o && !eav_o, "R5 guard bit error",
        {prot_err_o, sav_o, eav_o}, 3'b100);
    expect_flags("R5 flags held on error", 1'b1, 1'b0, 1'b1);
    push(8'h40, 8'h00);
    chk(!prot_err_o, "R5 error one cycle", prot_err_o, 0);
    preamble();
    push(mk_status(1'b0, 1'b0, 1'b0) & 8'h7F, 8'h00);
    chk(prot_err_o && !sav_o, "R5 bit7 clear error", {prot_err_o, sav_o}, 2'b10);
    expect_flags("R5 flags held on bit7 error", 1'b1, 1'b0, 1'b1);
    // an error inside a line must not close it
    send_code(1'b0, 1'b0, 1'b0);
    preamble();
    push(mk_status(1'b0, 1'b0, 1'b1) ^ 8'h01, 8'h00);
    push(8'h42, 8'h00);
    chk(act_valid_o && act_luma_o == 8'h42, "R5 active state held on error",
        {act_valid_o, act_luma_o}, {1'b1, 8'h42});
    send_code(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_restart();
    push(8'hFF, 8'h00);
    push(8'h00, 8'h00);
    send_code(1'b1, 1'b0, 1'b0);
    chk(sav_o, "R6 restart on 0xFF mid preamble", sav_o, 1);
    expect_flags("R6 flags after restart", 1'b1, 1'b0, 1'b0);
    send_code(1'b1, 1'b0, 1'b1);
    push(8'hFF, 8'h00);
    push(8'h00, 8'h00);
    push(8'h12, 8'h00);
    push(8'h00, 8'h00);
    push(mk_status(1'b0, 1'b0, 1'b0), 8'h00);
    chk(!sav_o && !eav_o && !prot_err_o, "R6 broken preamble ignored",
        {sav_o, eav_o, prot_err_o}, 0);
    expect_flags("R6 flags unchanged", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_vblank_sav();
    send_code(1'b0, 1'b1, 1'b0);
    chk(sav_o, "R4 start pulse in vblank", sav_o, 1);
    push(8'h33, 8'h00);
    chk(!act_valid_o, "R7 vblank start does not open", act_valid_o, 0);
  endtask

  task automatic t_dual();
    dual = 1'b1;
    push(8'h20, 8'hFF);
    push(8'h20, 8'h00);
    push(8'h20, 8'h00);
    push(8'h20, mk_status(1'b0, 1'b0, 1'b0));
    chk(!sav_o && !prot_err_o, "R9 chroma lane code ignored", {sav_o, prot_err_o}, 0);
    send_code(1'b0, 1'b0, 1'b0);
    chk(sav_o, "R9 dual mode start", sav_o, 1);
    push(8'h10, 8'h80);
    chk(act_valid_o && act_luma_o == 8'h10 && act_chroma_o == 8'h80,
        "R9 dual lane data", {act_valid_o, act_luma_o, act_chroma_o},
        {1'b1, 8'h10, 8'h80});
    push(8'hEB, 8'h0F);
    chk(act_chroma_o == 8'h0F && act_luma_o == 8'hEB, "R10 dual lane data",
        {act_luma_o, act_chroma_o}, {8'hEB, 8'h0F});
    send_code(1'b0, 1'b0, 1'b1);
    chk(eav_o && hblank_o, "R4 dual mode end", {eav_o, hblank_o}, 2'b11);
  endtask

  initial begin
    t_reset();
    t_single_line();
    t_all_codes();
    t_prot_err();
    t_restart();
    t_vblank_sav();
    t_dual();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule